// File: doc/BRIEF.md
# Drive Password Security Controller

This block holds the password-protection state of a storage drive. The host starts a security command with a one-cycle opcode strobe. Commands that carry a payload then deliver a 512-byte data block as a stream of 16-bit words. Word 0 is a control word and words 1 to 16 hold the 32-byte password. The block keeps a user password and a master password, and it tracks five conditions: security enabled, drive locked, frozen, erase armed, and the security level.

Each command ends with a one-cycle completion pulse that carries an aborted flag. A successful erase-unit command also raises a one-cycle request for the surrounding controller to wipe user data. Two reset inputs are provided. The asynchronous power-on reset clears everything. The synchronous hard reset thaws the block, clears the retry count and disarms erase, and it re-locks the drive when security is enabled. Non-volatile storage of the passwords, the media wipe itself and the host transport all belong to other blocks.

Top module: `sec_lock_top`

## Requirements
- R1: After power-on reset, all of these are low: `done`, `aborted`, `erase_req`, `sec_enabled`, `sec_locked`, `sec_frozen`, `sec_level_max` and `erase_armed`.
- R2: Set password (F1h) is aborted while locked. Otherwise, control bit 0 = 0 stores the user password, sets `sec_enabled` and takes `sec_level_max` from control bit 8 (0 High, 1 Maximum). Control bit 0 = 1 stores only the master password.
- R3: A hard reset clears frozen, the failure count and erase armed, and it sets `sec_locked` equal to `sec_enabled`. Both passwords are kept.
- R4: Unlock (F2h) clears the lock when the user password matches (bit 0 = 0) or the master password matches (bit 0 = 1). At Maximum level a master match is aborted. When security is disabled, unlock completes without effect.
- R5: Each failed unlock adds one to a failure count. Once the count reaches 5, unlock and erase unit are aborted until a hard reset.
- R6: While frozen, F1h, F2h, F3h, F4h and F6h are aborted and leave the state unchanged.
- R7: Freeze lock (F5h) sets `sec_frozen` and completes normally, and it also completes normally when already frozen. Only a reset clears frozen.
- R8: Erase unit (F4h) with a matching password raises `erase_req` with `done`. It clears `sec_enabled`, `sec_locked` and the user password. A master match is accepted at either level.
- R9: Erase prepare (F3h) sets `erase_armed`. Any other accepted command, including opcodes outside F1h to F6h (which complete normally), disarms it. F4h aborts unless it directly follows F3h.
- R10: Disable password (F6h) with a match clears `sec_enabled` and `sec_locked` and keeps the master password. It follows the unlock rules for matching, and a mismatch is aborted.
- R11: F1h, F2h, F4h and F6h take 256 payload words, with word i = 1 to 16 forming password bits [16i-1:16i-16]. `done` is a one-cycle pulse, registered on the edge after the edge that takes the last payload word, or after the edge that takes the strobe for a non-data command.
- R12: Payload words presented while no command is active, and strobes presented while a command is in progress, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hard_rst | input | 1 | Synchronous hard reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| wr_valid | input | 1 | Payload word valid |
| wr_data | input | 16 | Payload word |
| done | output | 1 | Command completion pulse |
| aborted | output | 1 | Completion status: command aborted |
| erase_req | output | 1 | Request to erase user data |
| sec_enabled | output | 1 | User password is in force |
| sec_locked | output | 1 | Drive is locked |
| sec_frozen | output | 1 | Security state is frozen |
| sec_level_max | output | 1 | Security level is Maximum |
| erase_armed | output | 1 | Erase prepare is pending |

## Verification
For a non-data command, the completion pulse with its aborted flag and erase request is due two rising edges after the strobe is driven: one edge samples the strobe and the next registers the result. For a payload command, the pulse is due two edges after the last word is driven. The state flags change on that same edge. The bench drives inputs on falling edges. It checks that `done` is still low one cycle after the final input and high exactly one cycle later, and it samples every other result in that same cycle. Hard-reset effects are sampled in the cycle after the reset pulse.

// File: rtl/sec_lock_pkg.sv
package sec_lock_pkg;

    localparam logic [7:0] OP_SET_PW   = 8'hF1;
    localparam logic [7:0] OP_UNLOCK   = 8'hF2;
    localparam logic [7:0] OP_ER_PREP  = 8'hF3;
    localparam logic [7:0] OP_ER_UNIT  = 8'hF4;
    localparam logic [7:0] OP_FREEZE   = 8'hF5;
    localparam logic [7:0] OP_DIS_PW   = 8'hF6;

    localparam int CTRL_SEL_BIT = 0;
    localparam int CTRL_LVL_BIT = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_EVAL = 2'd2
    } phase_e;

    function automatic logic op_has_payload(input logic [7:0] op);
        return (op == OP_SET_PW) || (op == OP_UNLOCK) ||
               (op == OP_ER_UNIT) || (op == OP_DIS_PW);
    endfunction

endpackage

// File: rtl/sec_pw_capture.sv
module sec_pw_capture #(
    parameter int WORD_W        = 16,
    parameter int PW_WORDS      = 16,
    parameter int PAYLOAD_WORDS = 256,
    localparam int IDX_W        = $clog2(PAYLOAD_WORDS),
    localparam int PW_BITS      = WORD_W * PW_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               take,
    input  logic [WORD_W-1:0]  word,
    output logic               sel_master,
    output logic               lvl_max,
    output logic [PW_BITS-1:0] pw,
    output logic               last
);
    import sec_lock_pkg::*;

    logic [IDX_W-1:0]  idx_q;
    logic              sel_q, lvl_q;
    logic [WORD_W-1:0] slot_q [PW_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            lvl_q <= 1'b0;
        end else if (take && idx_q == '0) begin
            sel_q <= word[CTRL_SEL_BIT];
            lvl_q <= word[CTRL_LVL_BIT];
        end
    end

    for (genvar g = 0; g < PW_WORDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (take && idx_q == IDX_W'(g + 1)) begin
                slot_q[g] <= word;
            end
        end
        assign pw[g*WORD_W +: WORD_W] = slot_q[g];
    end

    assign sel_master = sel_q;
    assign lvl_max    = lvl_q;
    assign last       = take && (idx_q == IDX_W'(PAYLOAD_WORDS - 1));

endmodule

// File: rtl/sec_pw_compare.sv
module sec_pw_compare #(
    parameter int WORD_W   = 16,
    parameter int PW_WORDS = 16,
    localparam int PW_BITS = WORD_W * PW_WORDS
) (
    input  logic [PW_BITS-1:0] cand,
    input  logic [PW_BITS-1:0] user_pw,
    input  logic [PW_BITS-1:0] master_pw,
    output logic               user_hit,
    output logic               master_hit
);
    logic [PW_WORDS-1:0] u_eq, m_eq;

    for (genvar g = 0; g < PW_WORDS; g++) begin : g_eq
        assign u_eq[g] = (cand[g*WORD_W +: WORD_W] == user_pw[g*WORD_W +: WORD_W]);
        assign m_eq[g] = (cand[g*WORD_W +: WORD_W] == master_pw[g*WORD_W +: WORD_W]);
    end

    assign user_hit   = &u_eq;
    assign master_hit = &m_eq;

endmodule

// File: rtl/sec_lock_top.sv
module sec_lock_top #(
    parameter int WORD_W        = 16,
    parameter int PW_WORDS      = 16,
    parameter int PAYLOAD_WORDS = 256,
    parameter int MAX_TRIES     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hard_rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              aborted,
    output logic              erase_req,
    output logic              sec_enabled,
    output logic              sec_locked,
    output logic              sec_frozen,
    output logic              sec_level_max,
    output logic              erase_armed
);
    import sec_lock_pkg::*;

    localparam int PW_BITS = WORD_W * PW_WORDS;
    localparam int FAIL_W  = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        phase_e             ph;
        logic [7:0]         op;
        logic               en;
        logic               lk;
        logic               fz;
        logic               lvl;
        logic               arm;
        logic [FAIL_W-1:0]  fails;
        logic [PW_BITS-1:0] upw;
        logic [PW_BITS-1:0] mpw;
        logic               done;
        logic               abrt;
        logic               ers;
    } st_t;

    st_t st_d, st_q;

    logic               take, clear, last;
    logic               sel_master, lvl_bit;
    logic [PW_BITS-1:0] cand_pw;
    logic               user_hit, master_hit;
    logic               pass_unlock, pass_erase, exhausted;
    logic [7:0]         cur_op;

    assign take  = (st_q.ph == PH_DATA) && wr_valid;
    assign clear = ((st_q.ph == PH_IDLE) && cmd_valid) || hard_rst;

    sec_pw_capture #(
        .WORD_W        (WORD_W),
        .PW_WORDS      (PW_WORDS),
        .PAYLOAD_WORDS (PAYLOAD_WORDS)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .take       (take),
        .word       (wr_data),
        .sel_master (sel_master),
        .lvl_max    (lvl_bit),
        .pw         (cand_pw),
        .last       (last)
    );

    sec_pw_compare #(
        .WORD_W   (WORD_W),
        .PW_WORDS (PW_WORDS)
    ) u_compare (
        .cand       (cand_pw),
        .user_pw    (st_q.upw),
        .master_pw  (st_q.mpw),
        .user_hit   (user_hit),
        .master_hit (master_hit)
    );

    assign exhausted   = (st_q.fails >= FAIL_W'(MAX_TRIES));
    assign pass_unlock = sel_master ? (master_hit && !st_q.lvl) : user_hit;
    assign pass_erase  = sel_master ? master_hit : user_hit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.abrt = 1'b0;
        st_d.ers  = 1'b0;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    st_d.op = cmd_op;
                    if (cmd_op != OP_ER_UNIT) begin
                        st_d.arm = 1'b0;
                    end
                    st_d.ph = op_has_payload(cmd_op) ? PH_DATA : PH_EVAL;
                end
            end
            PH_DATA: begin
                if (last) begin
                    st_d.ph = PH_EVAL;
                end
            end
            PH_EVAL: begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
                unique case (st_q.op)
                    OP_SET_PW: begin
                        if (st_q.fz || st_q.lk) begin
                            st_d.abrt = 1'b1;
                        end else if (sel_master) begin
                            st_d.mpw = cand_pw;
                        end else begin
                            st_d.upw = cand_pw;
                            st_d.en  = 1'b1;
                            st_d.lvl = lvl_bit;
                        end
                    end
                    OP_UNLOCK: begin
                        if (st_q.fz || exhausted) begin
                            st_d.abrt = 1'b1;
                        end else if (st_q.en) begin
                            if (pass_unlock) begin
                                st_d.lk = 1'b0;
                            end else begin
                                st_d.abrt  = 1'b1;
                                st_d.fails = st_q.fails + FAIL_W'(1);
                            end
                        end
                    end
                    OP_ER_PREP: begin
                        if (st_q.fz) begin
                            st_d.abrt = 1'b1;
                        end else begin
                            st_d.arm = 1'b1;
                        end
                    end
                    OP_ER_UNIT: begin
                        st_d.arm = 1'b0;
                        if (st_q.fz || !st_q.arm || exhausted || !pass_erase) begin
                            st_d.abrt = 1'b1;
                        end else begin
                            st_d.ers = 1'b1;
                            st_d.en  = 1'b0;
                            st_d.lk  = 1'b0;
                            st_d.lvl = 1'b0;
                            st_d.upw = '0;
                        end
                    end
                    OP_FREEZE: begin
                        st_d.fz = 1'b1;
                    end
                    OP_DIS_PW: begin
                        if (st_q.fz) begin
                            st_d.abrt = 1'b1;
                        end else if (st_q.en) begin
                            if (pass_unlock) begin
                                st_d.en  = 1'b0;
                                st_d.lk  = 1'b0;
                                st_d.lvl = 1'b0;
                                st_d.upw = '0;
                            end else begin
                                st_d.abrt = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            default: st_d.ph = PH_IDLE;
        endcase

        if (hard_rst) begin
            st_d.ph    = PH_IDLE;
            st_d.fz    = 1'b0;
            st_d.arm   = 1'b0;
            st_d.fails = '0;
            st_d.lk    = st_q.en;
            st_d.done  = 1'b0;
            st_d.abrt  = 1'b0;
            st_d.ers   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_op        = st_q.op;
    assign done          = st_q.done;
    assign aborted       = st_q.abrt;
    assign erase_req     = st_q.ers;
    assign sec_enabled   = st_q.en;
    assign sec_locked    = st_q.lk;
    assign sec_frozen    = st_q.fz;
    assign sec_level_max = st_q.lvl;
    assign erase_armed   = st_q.arm;

endmodule

// File: rtl/sec_lock_chk.sv
module sec_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hard_rst,
    input logic       done,
    input logic       aborted,
    input logic       erase_req,
    input logic       sec_enabled,
    input logic       sec_locked,
    input logic       sec_frozen,
    input logic       erase_armed,
    input logic [7:0] cur_op
);
    import sec_lock_pkg::*;

    // R8: an erase request is a successful completion
    p_erase_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (done && !aborted));

    // R8: erase leaves the drive unprotected
    p_erase_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (!sec_enabled && !sec_locked));

    // R9: erase only while armed during evaluation
    p_erase_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(erase_armed));

    // R6: password-changing commands abort while frozen
    p_frozen_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sec_frozen && (cur_op == OP_SET_PW || cur_op == OP_UNLOCK ||
         cur_op == OP_ER_PREP || cur_op == OP_ER_UNIT || cur_op == OP_DIS_PW))
        |-> aborted);

    // R7: frozen falls only through a hard reset
    p_thaw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_frozen) |-> $past(hard_rst));

    // R3: a locked drive always has security enabled
    p_lock_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_locked |-> sec_enabled);

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind sec_lock_top sec_lock_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hard_rst    (hard_rst),
    .done        (done),
    .aborted     (aborted),
    .erase_req   (erase_req),
    .sec_enabled (sec_enabled),
    .sec_locked  (sec_locked),
    .sec_frozen  (sec_frozen),
    .erase_armed (erase_armed),
    .cur_op      (cur_op)
);

// File: tb/sec_lock_top_bench.sv
module sec_lock_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hard_rst = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic        done, aborted, erase_req;
    logic        sec_enabled, sec_locked, sec_frozen, sec_level_max, erase_armed;

    int total = 0;
    int bad   = 0;
    logic res_ab, res_er;

    always #2 clk = ~clk;

    sec_lock_top u_sec_lock_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .hard_rst      (hard_rst),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .done          (done),
        .aborted       (aborted),
        .erase_req     (erase_req),
        .sec_enabled   (sec_enabled),
        .sec_locked    (sec_locked),
        .sec_frozen    (sec_frozen),
        .sec_level_max (sec_level_max),
        .erase_armed   (erase_armed)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] ctrl;
        logic [7:0]  seed;
        logic        ab;
        logic        er;
        logic        en;
        logic        lk;
        logic        fz;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{8'hF1, 16'h0000, 8'hA1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF1, 16'h0001, 8'hB2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF6, 16'h0000, 8'h55, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF6, 16'h0000, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'hF1, 16'h0100, 8'hA1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF3, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF4, 16'h0001, 8'hB2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'hF1, 16'h0000, 8'hA1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF3, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF2, 16'h0000, 8'hA1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF4, 16'h0000, 8'hA1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hF5, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hF5, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hF1, 16'h0000, 8'hC3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hF2, 16'h0000, 8'hA1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hF3, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hF4, 16'h0000, 8'hA1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hF6, 16'h0000, 8'hA1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] op, input logic fz);
        if (fz && op != 8'hF5) return "R6";
        case (op)
            8'hF1:   return "R2";
            8'hF2:   return "R4";
            8'hF3:   return "R9";
            8'hF4:   return "R8";
            8'hF5:   return "R7";
            8'hF6:   return "R10";
            default: return "R9";
        endcase
    endfunction

    // R11: drive strobe and payload, then check the completion cycle
    task automatic run_cmd(input logic [7:0] op, input logic [15:0] ctrl,
                           input logic [7:0] seed, input logic inj);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 8'hF1 || op == 8'hF2 || op == 8'hF4 || op == 8'hF6) begin
            for (int i = 0; i < 256; i++) begin
                wr_valid = 1'b1;
                if (i == 0)       wr_data = ctrl;
                else if (i <= 16) wr_data = {seed, 8'(i)};
                else              wr_data = 16'hFFFF;
                if (inj && i == 5) begin
                    cmd_valid = 1'b1;
                    cmd_op    = 8'hF5;
                end else begin
                    cmd_valid = 1'b0;
                end
                @(negedge clk);
            end
            wr_valid  = 1'b0;
            cmd_valid = 1'b0;
        end
        check("R11 done not early", done, 1'b0);
        @(negedge clk);
        check("R11 done due", done, 1'b1);
        res_ab = aborted;
        res_er = erase_req;
    endtask

    task automatic pulse_hard_rst();
        @(negedge clk);
        hard_rst = 1'b1;
        @(negedge clk);
        hard_rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R11: got hung expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done", done, 0);
        check("R1 aborted", aborted, 0);
        check("R1 erase_req", erase_req, 0);
        check("R1 enabled", sec_enabled, 0);
        check("R1 locked", sec_locked, 0);
        check("R1 frozen", sec_frozen, 0);
        check("R1 level", sec_level_max, 0);
        check("R1 armed", erase_armed, 0);

        for (int v = 0; v < NV; v++) begin
            string r;
            r = req_of(VEC[v].op, VEC[v].fz);
            run_cmd(VEC[v].op, VEC[v].ctrl, VEC[v].seed, 1'b0);
            check({r, " aborted"}, res_ab, VEC[v].ab);
            check({r, " erase_req"}, res_er, VEC[v].er);
            check({r, " enabled"}, sec_enabled, VEC[v].en);
            check({r, " locked"}, sec_locked, VEC[v].lk);
            check({r, " frozen"}, sec_frozen, VEC[v].fz);
        end

        // R3 / R7: hard reset thaws and re-locks
        pulse_hard_rst();
        check("R7 frozen cleared", sec_frozen, 0);
        check("R3 relocked", sec_locked, 1);
        check("R3 enabled kept", sec_enabled, 1);

        // R2: set password refused while locked
        run_cmd(8'hF1, 16'h0000, 8'hC3, 1'b0);
        check("R2 set while locked", res_ab, 1);

        // R4: master unlock at High level
        run_cmd(8'hF2, 16'h0001, 8'hB2, 1'b0);
        check("R4 master unlock high", res_ab, 0);
        check("R4 unlocked", sec_locked, 0);

        // R2: user password at Maximum level
        run_cmd(8'hF1, 16'h0100, 8'hA1, 1'b0);
        check("R2 set max", res_ab, 0);
        check("R2 level max", sec_level_max, 1);

        // R4: master refused for unlock at Maximum
        pulse_hard_rst();
        run_cmd(8'hF2, 16'h0001, 8'hB2, 1'b0);
        check("R4 master unlock max", res_ab, 1);
        check("R4 still locked", sec_locked, 1);
        run_cmd(8'hF2, 16'h0000, 8'hA1, 1'b0);
        check("R4 user unlock", res_ab, 0);
        check("R4 user unlocked", sec_locked, 0);

        // R5: retry limit
        pulse_hard_rst();
        for (int k = 0; k < 5; k++) begin
            run_cmd(8'hF2, 16'h0000, 8'h77, 1'b0);
            check("R5 wrong unlock", res_ab, 1);
        end
        run_cmd(8'hF2, 16'h0000, 8'hA1, 1'b0);
        check("R5 unlock after limit", res_ab, 1);
        check("R5 still locked", sec_locked, 1);
        run_cmd(8'hF3, 16'h0000, 8'h00, 1'b0);
        check("R9 prepare armed", erase_armed, 1);
        run_cmd(8'hF4, 16'h0000, 8'hA1, 1'b0);
        check("R5 erase after limit", res_ab, 1);
        check("R5 no erase", res_er, 0);
        pulse_hard_rst();
        run_cmd(8'hF2, 16'h0000, 8'hA1, 1'b0);
        check("R5 unlock after reset", res_ab, 0);
        check("R5 unlocked", sec_locked, 0);

        // R9: unrelated opcode disarms
        run_cmd(8'hF3, 16'h0000, 8'h00, 1'b0);
        check("R9 armed", erase_armed, 1);
        run_cmd(8'hE7, 16'h0000, 8'h00, 1'b0);
        check("R9 other op ok", res_ab, 0);
        check("R9 disarmed", erase_armed, 0);
        run_cmd(8'hF4, 16'h0000, 8'hA1, 1'b0);
        check("R9 erase unarmed", res_ab, 1);
        check("R9 enabled kept", sec_enabled, 1);

        // R12: idle payload words ignored
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = 16'h1234;
        end
        @(negedge clk);
        wr_valid = 1'b0;
        check("R12 idle words no done", done, 0);
        @(negedge clk);
        check("R12 idle words no done", done, 0);
        check("R12 state kept", {sec_enabled, sec_locked}, 2'b10);

        // R12: strobe while busy ignored
        run_cmd(8'hF6, 16'h0000, 8'hA1, 1'b1);
        check("R12 busy strobe result", res_ab, 0);
        check("R12 busy strobe not frozen", sec_frozen, 0);
        check("R10 disabled", sec_enabled, 0);

        // R10: master kept after disable
        run_cmd(8'hF1, 16'h0000, 8'hD4, 1'b0);
        check("R2 new user", sec_enabled, 1);
        run_cmd(8'hF6, 16'h0001, 8'hB2, 1'b0);
        check("R10 master still valid", res_ab, 0);
        check("R10 disabled by master", sec_enabled, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule